// File: doc/BRIEF.md
# Dual-Lane Serial ADC Sequencer

This block drives one complete sampling cycle of an external converter that has two serial data outputs. When a start request is accepted, it pulls the active-low conversion strobe low for a minimum width. At the same time it lowers chip select. It then waits for the converter's BUSY line to drop. After that it generates a serial clock and shifts both data lines in together, one bit per clock, into two result words. When the last bit is in, chip select rises and a one-cycle done pulse marks the new results. The results hold their value until the next done pulse.

All timing is derived at elaboration from the system clock period and the converter's limits in nanoseconds. These limits cover the strobe width, the BUSY rise window, the maximum conversion time, the serial clock ceiling, the quiet gap and the power-up delay. BUSY passes through a synchronizer and is ignored during a settling window after the strobe falls. If BUSY never drops, a timeout pulse ends the cycle. A start request that arrives while a cycle or quiet gap is running is remembered and served afterwards.

With the defaults (100 MHz clock, 12-bit results) the strobe is low for 1 cycle and BUSY is ignored for the first 4 cycles. The timeout fires 77 cycles after the strobe falls. Each serial clock phase is 2 cycles, the quiet gap is 3 cycles and the power-up wait is 7000 cycles.

Top module: `adc_dual_rd`

## Requirements
- R1: While reset is asserted, convstN, csN and sclk are high and done and timeout are low.
- R2: After reset is released, convstN does not fall until at least PWRUP_CYC (default 7000) clock cycles have passed. A start request made earlier is held and served once that delay has passed.
- R3: Each conversion strobe holds convstN low for at least LOW_CYC cycles (default 1, i.e. 10 ns) and then returns it high.
- R4: csN falls in the same cycle as convstN, stays low through the conversion, and is still low when BUSY falls.
- R5: BUSY is ignored for the first SETTLE_CYC cycles (default 4) after the strobe falls. The serial clock never falls while BUSY is still high.
- R6: sclk is high whenever csN is high. During a read it produces exactly DATA_W-1 falling edges, and each high or low phase lasts at least HALF_CYC cycles (default 2, 25 MHz at 100 MHz).
- R7: Both lanes are captured at the same time, most significant bit first. Bit DATA_W-1 of each result is the level present when BUSY falls. Every later bit is the level at the end of a low sclk phase.
- R8: done is high for exactly one cycle, in the cycle in which csN returns high. dataA and dataB then carry the new words, and they change at no other time.
- R9: csN stays high for at least QUIET_CYC cycles (default 3) between the end of a read and the next strobe fall.
- R10: If BUSY has not fallen TIMEOUT_CYC cycles (default 77) after the strobe falls, timeout pulses for one cycle and csN rises in that same cycle. No done follows, and the results are unchanged.
- R11: A start request that arrives during an active cycle or a quiet gap is held pending. Exactly one extra conversion then follows, however many requests arrived in that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request one conversion-and-read cycle |
| convstN | output | 1 | Active-low conversion strobe to the converter |
| busy | input | 1 | Converter busy flag (asynchronous) |
| csN | output | 1 | Active-low chip select to the converter |
| sclk | output | 1 | Serial read clock, idles high |
| doutA | input | 1 | Serial data, lane A |
| doutB | input | 1 | Serial data, lane B |
| dataA | output | DATA_W | Latest lane A result |
| dataB | output | DATA_W | Latest lane B result |
| done | output | 1 | One-cycle pulse when new results are loaded |
| timeout | output | 1 | One-cycle pulse when BUSY never fell |

## Verification
The bench models the converter. Its BUSY line sometimes rises a whole clock late, to catch a controller that reads before the settling window is over; such a design would drop sclk while BUSY is still high. Conversion times cover the shortest and longest cases, and data patterns that put a single set bit at the top catch an off-by-one in the bit order or in the count of clock edges. Requests that arrive during the read and during the quiet gap expose a lost or duplicated pending start, or a gap shorter than the quiet rule. A converter that never finishes checks that the timeout fires on the exact cycle, raises chip select, and leaves the results untouched.

// File: rtl/adc_dual_pkg.sv
package adc_dual_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLOW,
    ST_CWAIT,
    ST_READ,
    ST_QUIET
  } ctlState_t;

  typedef struct packed {
    logic shiftEn;
    logic loadOut;
  } dpCtl_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/adc_dual_ctrl.sv
module adc_dual_ctrl
  import adc_dual_pkg::*;
#(
  parameter int DATA_W            = 12,
  parameter int CLK_PERIOD_NS     = 10,
  parameter int CONVST_LOW_NS     = 10,
  parameter int BUSY_RISE_NS      = 5,
  parameter int CONV_MAX_NS       = 610,
  parameter int TIMEOUT_EXTRA_CYC = 16,
  parameter int SCLK_MAX_MHZ      = 35,
  parameter int QUIET_NS          = 30,
  parameter int PWRUP_NS          = 70000,
  parameter int SYNC_STAGES       = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   startReq,
  input  logic   busy,
  output logic   convstN,
  output logic   csN,
  output logic   sclk,
  output logic   timeout,
  output dpCtl_t dpCtl
);

  localparam int LOW_RAW     = ceilDiv(CONVST_LOW_NS, CLK_PERIOD_NS);
  localparam int LOW_CYC     = (LOW_RAW < 1) ? 1 : LOW_RAW;
  localparam int SETTLE_CYC  = ceilDiv(BUSY_RISE_NS, CLK_PERIOD_NS) + SYNC_STAGES + 1;
  localparam int TIMEOUT_CYC = ceilDiv(CONV_MAX_NS, CLK_PERIOD_NS) + TIMEOUT_EXTRA_CYC;
  localparam int HALF_RAW    = ceilDiv(ceilDiv(500, SCLK_MAX_MHZ), CLK_PERIOD_NS);
  localparam int HALF_CYC    = (HALF_RAW < 1) ? 1 : HALF_RAW;
  localparam int QUIET_RAW   = ceilDiv(QUIET_NS, CLK_PERIOD_NS);
  localparam int QUIET_CYC   = (QUIET_RAW < 1) ? 1 : QUIET_RAW;
  localparam int PWRUP_CYC   = ceilDiv(PWRUP_NS, CLK_PERIOD_NS);
  localparam int CNT_W       = $clog2(TIMEOUT_CYC + 1);
  localparam int PH_W        = $clog2(HALF_CYC + 1);
  localparam int BIT_W       = $clog2(DATA_W + 1);
  localparam int Q_W         = $clog2(QUIET_CYC + 1);
  localparam int PWR_W       = $clog2(PWRUP_CYC + 1);

  ctlState_t         state;
  logic [CNT_W-1:0]  convCnt;
  logic [PH_W-1:0]   phase;
  logic [BIT_W-1:0]  bitsLeft;
  logic [Q_W-1:0]    quietCnt;
  logic [PWR_W-1:0]  pwrCnt;
  logic              pwrOk;
  logic              pendQ;
  logic              busySync;
  logic              go;
  logic              readStart;
  logic              phaseEnd;
  logic              bitSample;
  logic              readEnd;

  // BUSY synchronizer; reset to "busy" so nothing reads early
  logic [SYNC_STAGES-1:0] busySh;
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) busySh <= '1;
        else       busySh <= busy;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) busySh <= '1;
        else       busySh <= {busySh[SYNC_STAGES-2:0], busy};
      end
    end
  endgenerate
  assign busySync = busySh[SYNC_STAGES-1];

  assign go        = (state == ST_IDLE) && pwrOk && (startReq || pendQ);
  assign readStart = (state == ST_CWAIT) && (convCnt >= CNT_W'(SETTLE_CYC)) && !busySync;
  assign phaseEnd  = (state == ST_READ) && (phase == PH_W'(HALF_CYC - 1));
  assign bitSample = phaseEnd && !sclk;
  assign readEnd   = phaseEnd && sclk && (bitsLeft == '0);

  assign dpCtl.shiftEn = readStart || bitSample;
  assign dpCtl.loadOut = readEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      convstN  <= 1'b1;
      csN      <= 1'b1;
      sclk     <= 1'b1;
      timeout  <= 1'b0;
      pendQ    <= 1'b0;
      convCnt  <= '0;
      phase    <= '0;
      bitsLeft <= '0;
      quietCnt <= '0;
      pwrCnt   <= '0;
      pwrOk    <= 1'b0;
    end else begin
      timeout <= 1'b0;
      pendQ   <= (pendQ || startReq) && !go;
      if (!pwrOk) begin
        if (pwrCnt == PWR_W'(PWRUP_CYC - 1)) pwrOk  <= 1'b1;
        else                                 pwrCnt <= pwrCnt + 1'b1;
      end
      unique case (state)
        ST_IDLE: begin
          if (go) begin
            convstN <= 1'b0;
            csN     <= 1'b0;
            convCnt <= '0;
            state   <= ST_CLOW;
          end
        end
        ST_CLOW: begin
          convCnt <= convCnt + 1'b1;
          if (convCnt == CNT_W'(LOW_CYC - 1)) begin
            convstN <= 1'b1;
            state   <= ST_CWAIT;
          end
        end
        ST_CWAIT: begin
          convCnt <= convCnt + 1'b1;
          if (readStart) begin
            phase    <= PH_W'(HALF_CYC - 1);
            bitsLeft <= BIT_W'(DATA_W - 1);
            state    <= ST_READ;
          end else if (convCnt == CNT_W'(TIMEOUT_CYC - 1)) begin
            timeout  <= 1'b1;
            csN      <= 1'b1;
            quietCnt <= '0;
            state    <= ST_QUIET;
          end
        end
        ST_READ: begin
          if (phaseEnd) begin
            phase <= '0;
            if (readEnd) begin
              csN      <= 1'b1;
              quietCnt <= '0;
              state    <= ST_QUIET;
            end else if (sclk) begin
              sclk <= 1'b0;
            end else begin
              sclk     <= 1'b1;
              bitsLeft <= bitsLeft - 1'b1;
            end
          end else begin
            phase <= phase + 1'b1;
          end
        end
        ST_QUIET: begin
          if (quietCnt == Q_W'(QUIET_CYC - 1)) state <= ST_IDLE;
          else                                 quietCnt <= quietCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // cycles chip select has been high, saturating, for the quiet-gap check
  logic [Q_W-1:0] sinceCsHigh;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  sinceCsHigh <= Q_W'(QUIET_CYC);
    else if (!csN)                              sinceCsHigh <= '0;
    else if (sinceCsHigh != Q_W'(QUIET_CYC))    sinceCsHigh <= sinceCsHigh + 1'b1;
  end

  p_cs_covers_strobe_r4: assert property (@(posedge clk) disable iff (!rstN)
    !convstN |-> !csN);

  p_sclk_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> sclk);

  p_pwrup_before_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(convstN) |-> pwrOk);

  p_quiet_gap_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(convstN) |-> (sinceCsHigh == Q_W'(QUIET_CYC)));

  p_timeout_releases_r10: assert property (@(posedge clk) disable iff (!rstN)
    timeout |-> (csN && convstN));

endmodule

// File: rtl/adc_dual_dp.sv
module adc_dual_dp
  import adc_dual_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              doutA,
  input  logic              doutB,
  output logic [DATA_W-1:0] dataA,
  output logic [DATA_W-1:0] dataB,
  output logic              done
);

  logic [DATA_W-1:0] shA;
  logic [DATA_W-1:0] shB;

  generate
    if (DATA_W == 1) begin : g_w1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          shA <= '0;
          shB <= '0;
        end else if (ctl.shiftEn) begin
          shA <= doutA;
          shB <= doutB;
        end
      end
    end else begin : g_wn
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          shA <= '0;
          shB <= '0;
        end else if (ctl.shiftEn) begin
          shA <= {shA[DATA_W-2:0], doutA};
          shB <= {shB[DATA_W-2:0], doutB};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataA <= '0;
      dataB <= '0;
      done  <= 1'b0;
    end else begin
      done <= ctl.loadOut;
      if (ctl.loadOut) begin
        dataA <= shA;
        dataB <= shB;
      end
    end
  end

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_result_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loadOut |=> ($stable(dataA) && $stable(dataB)));

  p_no_shift_on_load_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadOut |-> !ctl.shiftEn);

endmodule

// File: rtl/adc_dual_rd.sv
module adc_dual_rd
  import adc_dual_pkg::*;
#(
  parameter int DATA_W            = 12,
  parameter int CLK_PERIOD_NS     = 10,
  parameter int CONVST_LOW_NS     = 10,
  parameter int BUSY_RISE_NS      = 5,
  parameter int CONV_MAX_NS       = 610,
  parameter int TIMEOUT_EXTRA_CYC = 16,
  parameter int SCLK_MAX_MHZ      = 35,
  parameter int QUIET_NS          = 30,
  parameter int PWRUP_NS          = 70000,
  parameter int SYNC_STAGES       = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  output logic              convstN,
  input  logic              busy,
  output logic              csN,
  output logic              sclk,
  input  logic              doutA,
  input  logic              doutB,
  output logic [DATA_W-1:0] dataA,
  output logic [DATA_W-1:0] dataB,
  output logic              done,
  output logic              timeout
);

  dpCtl_t dpCtl;

  adc_dual_ctrl #(
    .DATA_W(DATA_W), .CLK_PERIOD_NS(CLK_PERIOD_NS), .CONVST_LOW_NS(CONVST_LOW_NS),
    .BUSY_RISE_NS(BUSY_RISE_NS), .CONV_MAX_NS(CONV_MAX_NS),
    .TIMEOUT_EXTRA_CYC(TIMEOUT_EXTRA_CYC), .SCLK_MAX_MHZ(SCLK_MAX_MHZ),
    .QUIET_NS(QUIET_NS), .PWRUP_NS(PWRUP_NS), .SYNC_STAGES(SYNC_STAGES)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .busy(busy),
    .convstN(convstN), .csN(csN), .sclk(sclk), .timeout(timeout), .dpCtl(dpCtl)
  );

  adc_dual_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(dpCtl), .doutA(doutA), .doutB(doutB),
    .dataA(dataA), .dataB(dataB), .done(done)
  );

endmodule

// File: tb/adc_dual_rd_tb_top.sv
module adc_dual_rd_tb_top;

  localparam int CLK_PERIOD  = 10;
  localparam int DATA_W      = 12;
  localparam int PWRUP_CYC   = 7000;
  localparam int LOW_CYC     = 1;
  localparam int HALF_CYC    = 2;
  localparam int QUIET_CYC   = 3;
  localparam int TIMEOUT_CYC = 77;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic busy = 1'b0;
  logic doutA = 1'b0;
  logic doutB = 1'b0;
  logic convstN, csN, sclk, done, timeout;
  logic [DATA_W-1:0] dataA, dataB;

  adc_dual_rd dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .convstN(convstN), .busy(busy),
    .csN(csN), .sclk(sclk), .doutA(doutA), .doutB(doutB), .dataA(dataA),
    .dataB(dataB), .done(done), .timeout(timeout)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int nChk = 0;
  int nBad = 0;
  int cyc = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] expWord(input logic [DATA_W-1:0] w);
    return w;
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
  endtask

  // converter model state
  bit hangMode = 0;
  bit lateBusy = 0;
  int convCyc = 10;
  logic [DATA_W-1:0] nextA = '0, nextB = '0, curA = '0, curB = '0;
  logic [DATA_W-1:0] expA = '0, expB = '0, lastA = '0, lastB = '0;
  int bitIdx = 0;

  always @(posedge clk) if (rstN) cyc++;

  always begin
    @(negedge convstN);
    curA = nextA;
    curB = nextB;
    if (lateBusy) begin
      @(posedge clk);
      #1;
    end else begin
      #2;
    end
    busy = 1'b1;
    if (hangMode) begin
      @(posedge csN);
      busy = 1'b0;
    end else begin
      repeat (convCyc) @(posedge clk);
      #1;
      check(csN === 1'b0, "R4", "csN when BUSY falls", longint'(csN), 0);
      expA = expWord(curA);
      expB = expWord(curB);
      busy = 1'b0;
      bitIdx = 0;
      doutA = curA[DATA_W-1];
      doutB = curB[DATA_W-1];
      while (csN === 1'b0) begin
        @(negedge sclk or posedge csN);
        if (csN === 1'b0) begin
          bitIdx++;
          #1;
          if (bitIdx < DATA_W) begin
            doutA = curA[DATA_W-1-bitIdx];
            doutB = curB[DATA_W-1-bitIdx];
          end
        end
      end
    end
  end

  // port monitor, sampled away from the active edge
  logic pConv = 1, pCs = 1, pSclk = 1, pDone = 0;
  int fallCyc = 0, csRiseCyc = -100, sclkEdgeCyc = 0, falls = 0;
  int convCount = 0, doneCount = 0, toCount = 0;
  bit firstFall = 1, haveRes = 0, holdBad = 0, toRun = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (pConv && !convstN) begin
        convCount++;
        fallCyc = cyc;
        falls = 0;
        toRun = 0;
        if (firstFall)
          check(cyc >= PWRUP_CYC, "R2", "first strobe cycle", cyc, PWRUP_CYC);
        firstFall = 0;
        check(cyc - csRiseCyc >= QUIET_CYC, "R9", "quiet gap", cyc - csRiseCyc, QUIET_CYC);
        check(csN == 1'b0, "R4", "csN at strobe fall", longint'(csN), 0);
      end
      if (!pConv && convstN)
        check(cyc - fallCyc >= LOW_CYC, "R3", "strobe low width", cyc - fallCyc, LOW_CYC);
      if (!csN && pSclk && !sclk) begin
        falls++;
        if (busy) check(0, "R5", "sclk fell while BUSY high", 1, 0);
        if (falls > 1)
          check(cyc - sclkEdgeCyc >= HALF_CYC, "R6", "sclk high phase", cyc - sclkEdgeCyc, HALF_CYC);
        sclkEdgeCyc = cyc;
      end
      if (!csN && !pSclk && sclk) begin
        check(cyc - sclkEdgeCyc >= HALF_CYC, "R6", "sclk low phase", cyc - sclkEdgeCyc, HALF_CYC);
        sclkEdgeCyc = cyc;
      end
      if (csN && !sclk) check(0, "R6", "sclk low with csN high", 0, 1);
      if (timeout) begin
        toCount++;
        toRun = 1;
        check(cyc - fallCyc == TIMEOUT_CYC, "R10", "timeout cycle", cyc - fallCyc, TIMEOUT_CYC);
        check(csN == 1'b1, "R10", "csN with timeout", longint'(csN), 1);
        check(!done, "R10", "done with timeout", longint'(done), 0);
      end
      if (!pCs && csN) begin
        csRiseCyc = cyc;
        if (!toRun) begin
          check(falls == DATA_W - 1, "R6", "sclk falling edges", falls, DATA_W - 1);
          check(done == 1'b1, "R8", "done with csN rise", longint'(done), 1);
        end
      end
      if (done) begin
        doneCount++;
        if (pDone) check(0, "R8", "done longer than one cycle", 2, 1);
        check(dataA == expA, "R7", "lane A word", dataA, expA);
        check(dataB == expB, "R7", "lane B word", dataB, expB);
        lastA = dataA;
        lastB = dataB;
        haveRes = 1;
      end else if (haveRes && (dataA !== lastA || dataB !== lastB)) begin
        holdBad = 1;
      end
      pConv = convstN;
      pCs = csN;
      pSclk = sclk;
      pDone = done;
    end
  end

  task automatic pulseStart();
    @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic waitDone(input int target);
    while (doneCount < target) @(negedge clk);
  endtask

  task automatic oneConv(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b,
                         input int cc, input bit late);
    int d;
    d = doneCount;
    nextA = a;
    nextB = b;
    convCyc = cc;
    lateBusy = late;
    pulseStart();
    waitDone(d + 1);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd5150));
    repeat (4) @(negedge clk);
    // R1: reset state
    check(convstN == 1'b1, "R1", "convstN in reset", longint'(convstN), 1);
    check(csN == 1'b1, "R1", "csN in reset", longint'(csN), 1);
    check(sclk == 1'b1, "R1", "sclk in reset", longint'(sclk), 1);
    check(done == 1'b0, "R1", "done in reset", longint'(done), 0);
    check(timeout == 1'b0, "R1", "timeout in reset", longint'(timeout), 0);
    rstN = 1'b1;

    // R2: request during power-up wait is held
    oneConv(12'hA5C, 12'h3B1, 20, 0);
    // R7: distinct patterns on both lanes
    oneConv(12'hFFF, 12'h000, 10, 0);
    oneConv(12'hAAA, 12'h555, 30, 0);
    oneConv(12'h800, 12'h001, 5, 0);
    // R5: late BUSY rise and shortest / longest conversions
    oneConv(12'h7FE, 12'hC03, 1, 1);
    oneConv(12'h123, 12'hEDC, 60, 1);
    oneConv(12'h001, 12'h800, 1, 0);

    // R10: converter never finishes
    begin
      int d0, t0;
      d0 = doneCount;
      t0 = toCount;
      hangMode = 1;
      pulseStart();
      while (toCount == t0) @(negedge clk);
      repeat (10) @(negedge clk);
      hangMode = 0;
      check(doneCount == d0, "R10", "done count after timeout", doneCount, d0);
      check(dataA == lastA && dataB == lastB, "R10", "results after timeout", dataA, lastA);
    end
    oneConv(12'h0F0, 12'hF0F, 15, 0);

    // R11: requests during the read and in the quiet gap
    begin
      int c0, d0;
      c0 = convCount;
      d0 = doneCount;
      nextA = 12'h321;
      nextB = 12'h654;
      convCyc = 12;
      lateBusy = 0;
      pulseStart();
      while (convCount == c0) @(negedge clk);
      nextA = 12'h9AB;
      nextB = 12'hCDE;
      while (sclk) @(negedge clk);
      pulseStart();
      pulseStart();
      waitDone(d0 + 2);
      while (!csN) @(negedge clk);
      repeat (1) @(negedge clk);
      pulseStart();
      waitDone(d0 + 3);
      repeat (QUIET_CYC + 20) @(negedge clk);
      check(convCount == c0 + 3, "R11", "conversions from held requests", convCount, c0 + 3);
      check(doneCount == d0 + 3, "R11", "done count", doneCount, d0 + 3);
    end

    // random mix
    for (int i = 0; i < 40; i++) begin
      logic [DATA_W-1:0] ra, rb;
      ra = DATA_W'($urandom);
      rb = DATA_W'($urandom);
      oneConv(ra, rb, 1 + int'($urandom % 60), bit'($urandom % 2));
      repeat ($urandom % 8) @(negedge clk);
    end

    check(!holdBad, "R8", "results changed without done", longint'(holdBad), 0);
    check(convCount == doneCount + toCount, "R11", "conversions vs completions",
          convCount, doneCount + toCount);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChk++;
    nBad++;
    $display("FAIL R11 watchdog: actual hung expected completion (%0d dones)", doneCount);
    summary();
    $finish;
  end

endmodule